// File: doc/BRIEF.md
# External Data Memory Bus Interface

This block sits between a CPU's external-data-memory request port and a set of shared port pins. Each request asks for one byte, read or write. The block either serves it from an on-chip RAM port or runs an off-chip bus cycle on the pins. The choice follows a two-bit memory-map mode and, in the split modes, a fixed on-chip boundary. An off-chip cycle drives a 16-bit address and active-low read and write strobes. It also drives an 8-bit data bus whose drivers are switched off for reads. The bus can run in two ways. In multiplexed operation, the low address byte and the data share the same eight pins, and an address latch enable pulse marks the address. In non-multiplexed operation, the low address has its own pins.

The pins belong to the block only while an off-chip cycle runs. At every other time, each pin output, including the strobes, shows the value of the general-purpose port latch that the surrounding port logic supplies, and the data drivers stay enabled. The block never chooses the pad output type. Per-phase lengths, counted in clocks, are configuration inputs. Only one access is in flight at a time. Read data comes back with a single-cycle `done` pulse.

Top module: `emif_bus`

## Requirements
- R1: While reset is active, every pin output equals its port latch input, `ad_oe` is 1, and both `done` and `ram_en` are 0.
- R2: `cfg_mode` selects where an access goes: 0 sends every address on-chip, 1 and 2 (the split modes) send addresses below ONCHIP_BYTES (2048) on-chip and the rest off-chip, and 3 sends every address off-chip. An on-chip access leaves all pins at their latch values, and an off-chip access never raises `ram_en`.
- R3: An on-chip access raises `ram_en` for exactly one cycle, in the cycle after `req` is sampled. That cycle carries `ram_addr` = address modulo ONCHIP_BYTES, plus `ram_we` and `ram_wdata`. `done` rises two cycles later, with `rdata` set to the RAM's registered read data.
- R4: In an off-chip access, the address-setup phase lasts `cfg_setup`+1 cycles, the strobe phase `cfg_pulse`+1 cycles and the hold phase `cfg_hold`+1 cycles. In non-multiplexed operation (`cfg_mux`=0) the first cycle after `req` is sampled is the first setup cycle, and `alo_out` carries address bits 7:0 throughout.
- R5: With `cfg_mux`=1, the access opens with `ale_out` high for `cfg_ale`+1 cycles, during which `ad_out` carries address bits 7:0 with `ad_oe`=1. From the cycle after ALE falls, that address is gone from the `ad` pins. In this mode `alo_out` stays at its latch value.
- R6: During an off-chip access, `ahi_out` carries `cfg_page` in mode 1 and address bits 15:8 in modes 2 and 3.
- R7: Outside the ALE phase of an off-chip access, a write drives `wdata` on `ad_out` with `ad_oe`=1, and a read holds `ad_oe`=0.
- R8: A read captures `ad_in` into `rdata` on the clock edge where `rd_n_out` rises. `done` rises in the cycle after the last hold cycle. A write leaves `rdata` unchanged.
- R9: Whenever no off-chip access is running, every pin output equals its latch input, `lat_ctl` being {ale, rd_n, wr_n} from bit 2 down to bit 0. During an access, `ale_out` follows its latch in non-multiplexed operation.
- R10: In an off-chip access, `rd_n_out` (read) or `wr_n_out` (write) is low only during the strobe phase, and the other strobe stays high.
- R11: A `req` that arrives while an access is running is ignored: the running access is unchanged, and no further access follows it.
- R12: `done` is a single-cycle pulse, one per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mux | input | 1 | 1 = low address and data share the `ad` pins |
| cfg_mode | input | 2 | Memory-map mode, encoded as in R2 |
| cfg_ale | input | CNT_W | ALE width minus one, in clocks |
| cfg_setup | input | CNT_W | Address setup minus one, in clocks |
| cfg_pulse | input | CNT_W | Strobe width minus one, in clocks |
| cfg_hold | input | CNT_W | Address hold minus one, in clocks |
| cfg_page | input | 8 | Upper address byte for mode 1 |
| req | input | 1 | Access request, sampled while idle |
| addr | input | 16 | Access address |
| we | input | 1 | 1 = write |
| wdata | input | 8 | Write byte |
| done | output | 1 | Access complete pulse |
| rdata | output | 8 | Last read byte |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write |
| ram_addr | output | log2(ONCHIP_BYTES) | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write byte |
| ram_rdata | input | 8 | On-chip RAM registered read byte |
| lat_ad | input | 8 | Port latch for the `ad` pins |
| lat_alo | input | 8 | Port latch for the low-address pins |
| lat_ahi | input | 8 | Port latch for the high-address pins |
| lat_ctl | input | 3 | Port latch for {ale, rd_n, wr_n} |
| ad_out | output | 8 | Data / multiplexed address-data pins |
| ad_oe | output | 1 | Driver enable for `ad_out` |
| ad_in | input | 8 | Pad input of the `ad` pins |
| alo_out | output | 8 | Low-address pins (non-multiplexed) |
| ahi_out | output | 8 | High-address pins |
| ale_out | output | 1 | Address latch enable pin |
| rd_n_out | output | 1 | Read strobe pin, active low |
| wr_n_out | output | 1 | Write strobe pin, active low |

## Verification
`req` is sampled on an edge. The first on-chip or off-chip phase cycle is the one right after that edge. `done` comes one cycle after the final phase cycle, which makes it two cycles after the RAM-enable cycle for on-chip accesses. For off-chip accesses it falls at (multiplexed ? ALE+1 : 0) + setup+1 + pulse+1 + hold+1 cycles after the sampling edge. The bench drives inputs and samples outputs on falling edges. It computes the phase of each off-chip cycle from the configured counts, checks every cycle's strobes, address pins and data bus against that phase, and then checks `done`/`rdata` one cycle past the last hold cycle and the release of the pins in the cycle after that. It sweeps all four memory modes, both bus modes, reads and writes, boundary addresses and two timing sets.

// File: rtl/emif_pkg.sv
package emif_pkg;
  typedef enum logic [1:0] {
    MM_ONCHIP     = 2'd0,
    MM_SPLIT      = 2'd1,
    MM_SPLIT_BANK = 2'd2,
    MM_OFFCHIP    = 2'd3
  } memmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ONACC,
    ST_ONWAIT,
    ST_ALE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } phase_e;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
endpackage

// File: rtl/emif_route.sv
module emif_route
  import emif_pkg::*;
#(
  parameter int unsigned ONCHIP_BYTES = 2048
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] page,
  output logic          on_chip,
  output logic [DW-1:0] hi_byte
);
  logic below;

  assign below = ({1'b0, addr} < (AW+1)'(ONCHIP_BYTES));

  always_comb begin
    unique case (memmode_e'(mode))
      MM_ONCHIP:  on_chip = 1'b1;
      MM_OFFCHIP: on_chip = 1'b0;
      default:    on_chip = below;
    endcase
    hi_byte = (memmode_e'(mode) == MM_SPLIT) ? page : addr[AW-1:AW-DW];
  end
endmodule

// File: rtl/emif_seq.sv
module emif_seq
  import emif_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             on_chip,
  input  logic             mux,
  input  logic [CNT_W-1:0] t_ale,
  input  logic [CNT_W-1:0] t_setup,
  input  logic [CNT_W-1:0] t_pulse,
  input  logic [CNT_W-1:0] t_hold,
  output phase_e           state,
  output logic             accept,
  output logic             strobe_end,
  output logic             finish
);
  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last   = (cnt_q == '0);
  assign accept = (st_q == ST_IDLE) && req;
  assign state  = st_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    strobe_end = 1'b0;
    finish     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (on_chip) begin
            st_d = ST_ONACC;
          end else if (mux) begin
            st_d  = ST_ALE;
            cnt_d = t_ale;
          end else begin
            st_d  = ST_SETUP;
            cnt_d = t_setup;
          end
        end
      end
      ST_ONACC:  st_d = ST_ONWAIT;
      ST_ONWAIT: begin
        st_d   = ST_IDLE;
        finish = 1'b1;
      end
      ST_ALE: begin
        if (last) begin
          st_d  = ST_SETUP;
          cnt_d = t_setup;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SETUP: begin
        if (last) begin
          st_d  = ST_STROBE;
          cnt_d = t_pulse;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STROBE: begin
        if (last) begin
          st_d       = ST_HOLD;
          cnt_d      = t_hold;
          strobe_end = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (last) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/emif_pins.sv
module emif_pins
  import emif_pkg::*;
(
  input  phase_e        state,
  input  logic          mux,
  input  logic          wr,
  input  logic [DW-1:0] a_lo,
  input  logic [DW-1:0] a_hi,
  input  logic [DW-1:0] wd,
  input  logic [DW-1:0] lat_ad,
  input  logic [DW-1:0] lat_alo,
  input  logic [DW-1:0] lat_ahi,
  input  logic [2:0]    lat_ctl,
  output logic          own,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] alo_out,
  output logic [DW-1:0] ahi_out,
  output logic          ale_out,
  output logic          rd_n_out,
  output logic          wr_n_out
);
  logic in_ale, in_strobe;

  assign in_ale    = (state == ST_ALE);
  assign in_strobe = (state == ST_STROBE);
  assign own       = (state == ST_ALE) || (state == ST_SETUP) ||
                     (state == ST_STROBE) || (state == ST_HOLD);

  always_comb begin
    ad_out   = lat_ad;
    ad_oe    = 1'b1;
    alo_out  = lat_alo;
    ahi_out  = lat_ahi;
    ale_out  = lat_ctl[2];
    rd_n_out = lat_ctl[1];
    wr_n_out = lat_ctl[0];
    if (own) begin
      rd_n_out = ~(in_strobe & ~wr);
      wr_n_out = ~(in_strobe & wr);
      ahi_out  = a_hi;
      if (mux) begin
        ale_out = in_ale;
      end else begin
        alo_out = a_lo;
      end
      if (mux && in_ale) begin
        ad_out = a_lo;
      end else if (wr) begin
        ad_out = wd;
      end else begin
        ad_oe  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/emif_bus.sv
module emif_bus
  import emif_pkg::*;
#(
  parameter int unsigned ONCHIP_BYTES = 2048,
  parameter int unsigned CNT_W        = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_mux,
  input  logic [1:0]                      cfg_mode,
  input  logic [CNT_W-1:0]                cfg_ale,
  input  logic [CNT_W-1:0]                cfg_setup,
  input  logic [CNT_W-1:0]                cfg_pulse,
  input  logic [CNT_W-1:0]                cfg_hold,
  input  logic [7:0]                      cfg_page,
  input  logic                            req,
  input  logic [15:0]                     addr,
  input  logic                            we,
  input  logic [7:0]                      wdata,
  output logic                            done,
  output logic [7:0]                      rdata,
  output logic                            ram_en,
  output logic                            ram_we,
  output logic [$clog2(ONCHIP_BYTES)-1:0] ram_addr,
  output logic [7:0]                      ram_wdata,
  input  logic [7:0]                      ram_rdata,
  input  logic [7:0]                      lat_ad,
  input  logic [7:0]                      lat_alo,
  input  logic [7:0]                      lat_ahi,
  input  logic [2:0]                      lat_ctl,
  output logic [7:0]                      ad_out,
  output logic                            ad_oe,
  input  logic [7:0]                      ad_in,
  output logic [7:0]                      alo_out,
  output logic [7:0]                      ahi_out,
  output logic                            ale_out,
  output logic                            rd_n_out,
  output logic                            wr_n_out
);
  localparam int unsigned RAW = $clog2(ONCHIP_BYTES);

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          on_chip;
  logic [DW-1:0] hi_byte;
  phase_e        state;
  logic          accept, strobe_end, finish, own;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] hi_q, wd_q, rdata_q, rdata_d;
  logic          we_q, mux_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  emif_route #(.ONCHIP_BYTES(ONCHIP_BYTES)) u_route (
    .mode(cfg_mode), .addr(addr), .page(cfg_page),
    .on_chip(on_chip), .hi_byte(hi_byte)
  );

  emif_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .req(req), .on_chip(on_chip), .mux(cfg_mux),
    .t_ale(cfg_ale), .t_setup(cfg_setup), .t_pulse(cfg_pulse), .t_hold(cfg_hold),
    .state(state), .accept(accept), .strobe_end(strobe_end), .finish(finish)
  );

  emif_pins u_pins (
    .state(state), .mux(mux_q), .wr(we_q),
    .a_lo(addr_q[DW-1:0]), .a_hi(hi_q), .wd(wd_q),
    .lat_ad(lat_ad), .lat_alo(lat_alo), .lat_ahi(lat_ahi), .lat_ctl(lat_ctl),
    .own(own), .ad_out(ad_out), .ad_oe(ad_oe), .alo_out(alo_out),
    .ahi_out(ahi_out), .ale_out(ale_out), .rd_n_out(rd_n_out), .wr_n_out(wr_n_out)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (strobe_end && !we_q)                 rdata_d = ad_in;
    else if (state == ST_ONWAIT && !we_q)    rdata_d = ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      hi_q    <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
      mux_q   <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= addr;
        hi_q   <= hi_byte;
        wd_q   <= wdata;
        we_q   <= we;
        mux_q  <= cfg_mux;
      end
      rdata_q <= rdata_d;
      done_q  <= finish;
    end
  end

  assign done      = done_q;
  assign rdata     = rdata_q;
  assign ram_en    = (state == ST_ONACC);
  assign ram_we    = (state == ST_ONACC) && we_q;
  assign ram_addr  = addr_q[RAW-1:0];
  assign ram_wdata = wd_q;
endmodule

// File: rtl/emif_chk.sv
module emif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       own,
  input logic       mux_q,
  input logic       rd_n_out,
  input logic       wr_n_out,
  input logic       ale_out,
  input logic [2:0] lat_ctl,
  input logic [7:0] ad_in,
  input logic [7:0] rdata,
  input logic       done,
  input logic       ram_en
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own |-> (rd_n_out || wr_n_out));

  // R9
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own |-> (ale_out == lat_ctl[2] && rd_n_out == lat_ctl[1] && wr_n_out == lat_ctl[0]));

  // R8
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own && $rose(rd_n_out)) |-> (rdata == $past(ad_in)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  ram_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> !ram_en);

  // R2
  ram_vs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !own);

  // R5
  ale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own && mux_q && $fell(ale_out)) |-> (rd_n_out && wr_n_out));
endmodule

bind emif_bus emif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .own(own), .mux_q(mux_q),
  .rd_n_out(rd_n_out), .wr_n_out(wr_n_out), .ale_out(ale_out),
  .lat_ctl(lat_ctl), .ad_in(ad_in), .rdata(rdata), .done(done), .ram_en(ram_en)
);

// File: tb/tb_emif_bus.sv
`timescale 1ns/1ps
module tb_emif_bus;
  logic        clk, rst_n;
  logic        cfg_mux;
  logic [1:0]  cfg_mode;
  logic [3:0]  cfg_ale, cfg_setup, cfg_pulse, cfg_hold;
  logic [7:0]  cfg_page;
  logic        req, we;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        done;
  logic [7:0]  rdata;
  logic        ram_en, ram_we;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [7:0]  ad_out, ad_in, alo_out, ahi_out;
  logic        ad_oe, ale_out, rd_n_out, wr_n_out;
  logic [7:0]  rd_val;
  logic [7:0]  last_rd;

  localparam logic [7:0] LAT_AD  = 8'hC3;
  localparam logic [7:0] LAT_ALO = 8'h3C;
  localparam logic [7:0] LAT_AHI = 8'hA5;
  localparam logic [2:0] LAT_CTL = 3'b111;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  emif_bus dut (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_mode(cfg_mode),
    .cfg_ale(cfg_ale), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
    .cfg_page(cfg_page), .req(req), .addr(addr), .we(we), .wdata(wdata),
    .done(done), .rdata(rdata), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .lat_ad(LAT_AD), .lat_alo(LAT_ALO), .lat_ahi(LAT_AHI), .lat_ctl(LAT_CTL),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .alo_out(alo_out), .ahi_out(ahi_out),
    .ale_out(ale_out), .rd_n_out(rd_n_out), .wr_n_out(wr_n_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Off-chip device: answers only while the read strobe is low.
  assign ad_in = rd_n_out ? 8'h00 : rd_val;

  // On-chip RAM model with one-cycle registered read.
  function automatic logic [7:0] ram_fn(input logic [10:0] a);
    return a[7:0] ^ {5'b0, a[10:8]} ^ 8'h96;
  endfunction
  always @(posedge clk) ram_rdata <= ram_en ? ram_fn(ram_addr) : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    logic [35:0] a, e;
    a = {ad_out, ad_oe, alo_out, ahi_out, ale_out, rd_n_out, wr_n_out};
    e = {LAT_AD, 1'b1, LAT_ALO, LAT_AHI, LAT_CTL};
    chk(a == e, tag, 64'(a), 64'(e));
  endtask

  task automatic access(input logic m, input logic [1:0] md, input logic [15:0] a,
                        input logic w, input logic [7:0] d, input logic [3:0] ta,
                        input logic [3:0] ts, input logic [3:0] tp, input logic [3:0] th,
                        input bit poke);
    bit on;
    logic [7:0] hi, exp_rd;
    int na, ns, np, nh, n;
    on = (md == 2'd0) ? 1'b1 : (md == 2'd3) ? 1'b0 : (a < 16'd2048);
    hi = (md == 2'd1) ? cfg_page : a[15:8];
    @(negedge clk);
    cfg_mux = m; cfg_mode = md; cfg_ale = ta; cfg_setup = ts; cfg_pulse = tp; cfg_hold = th;
    addr = a; we = w; wdata = d; req = 1'b1;
    rd_val = a[7:0] ^ a[15:8] ^ 8'h5A;
    @(negedge clk);
    req = 1'b0;
    if (on) begin
      exp_rd = ram_fn(a[10:0]);
      chk(ram_en && ram_we == w && ram_addr == a[10:0], "R2 R3 ram enable/address",
          64'({ram_en, ram_we, ram_addr}), 64'({1'b1, w, a[10:0]}));
      if (w) chk(ram_wdata == d, "R3 ram write data", 64'(ram_wdata), 64'(d));
      chk_idle("R2 R9 pins during on-chip access");
      @(negedge clk);
      chk(!ram_en && !done, "R3 ram enable single cycle", 64'({ram_en, done}), 64'(0));
      @(negedge clk);
      chk(done, "R3 on-chip done", 64'(done), 64'(1));
    end else begin
      exp_rd = rd_val;
      na = m ? int'(ta) + 1 : 0;
      ns = int'(ts) + 1; np = int'(tp) + 1; nh = int'(th) + 1;
      n = na + ns + np + nh;
      for (int k = 0; k < n; k++) begin
        logic strobe, e_oe;
        logic [7:0] e_ad, e_alo, a_ad;
        if (k > 0) @(negedge clk);
        req = 1'b0;
        strobe = (k >= na + ns) && (k < na + ns + np);
        if (m && k < na) begin e_oe = 1'b1; e_ad = a[7:0]; end
        else if (w)      begin e_oe = 1'b1; e_ad = d; end
        else             begin e_oe = 1'b0; e_ad = 8'h00; end
        a_ad = ad_oe ? ad_out : 8'h00;
        e_alo = m ? LAT_ALO : a[7:0];
        chk({rd_n_out, wr_n_out, ale_out} == {~(strobe & ~w), ~(strobe & w), m ? (k < na) : 1'b1},
            "R5 R9 R10 strobes/ALE", 64'({rd_n_out, wr_n_out, ale_out}),
            64'({~(strobe & ~w), ~(strobe & w), m ? (k < na) : 1'b1}));
        chk({ahi_out, alo_out} == {hi, e_alo}, "R4 R5 R6 address pins",
            64'({ahi_out, alo_out}), 64'({hi, e_alo}));
        chk({ad_oe, a_ad} == {e_oe, e_ad}, "R5 R7 data bus", 64'({ad_oe, a_ad}), 64'({e_oe, e_ad}));
        chk(!ram_en && !done, "R2 R4 no ram/done mid-access", 64'({ram_en, done}), 64'(0));
        if (poke && k == 1) begin req = 1'b1; addr = 16'h0123; we = 1'b0; end
      end
      @(negedge clk);
      req = 1'b0;
      chk(done, "R8 off-chip done", 64'(done), 64'(1));
      chk_idle("R9 pins released at done");
    end
    if (w) begin
      chk(rdata == last_rd, "R8 write leaves rdata", 64'(rdata), 64'(last_rd));
    end else begin
      chk(rdata == exp_rd, "R3 R8 read data", 64'(rdata), 64'(exp_rd));
      last_rd = exp_rd;
    end
    @(negedge clk);
    chk(!done && !ram_en, "R11 R12 done single, nothing follows", 64'({done, ram_en}), 64'(0));
    chk_idle("R9 R11 pins idle after access");
    if (poke) begin
      @(negedge clk);
      chk(!done && !ram_en, "R11 ignored request", 64'({done, ram_en}), 64'(0));
      chk_idle("R11 pins stay idle");
    end
  endtask

  initial begin
    logic [15:0] addrs [4];
    addrs[0] = 16'h0000; addrs[1] = 16'h07FF; addrs[2] = 16'h0800; addrs[3] = 16'hBEEF;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    cfg_mux = 1'b0; cfg_mode = 2'd0; cfg_ale = '0; cfg_setup = '0; cfg_pulse = '0; cfg_hold = '0;
    cfg_page = 8'h6D; rd_val = 8'h00; last_rd = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_idle("R1 pins at reset");
    chk(!done && !ram_en, "R1 done/ram_en at reset", 64'({done, ram_en}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdata == 8'h00 && !done, "R1 rdata after reset", 64'(rdata), 64'(0));
    for (int t = 0; t < 2; t++)
      for (int md = 0; md < 4; md++)
        for (int m = 0; m < 2; m++)
          for (int w = 0; w < 2; w++)
            for (int i = 0; i < 4; i++)
              if (t == 0) access(m[0], md[1:0], addrs[i], w[0], 8'h11 + 8'(i * 37), 4'd0, 4'd0, 4'd0, 4'd0, 1'b0);
              else        access(m[0], md[1:0], addrs[i], w[0], 8'hE2 ^ 8'(i * 19), 4'd2, 4'd1, 4'd3, 4'd2, 1'b0);
    // R11 request during a running access, both bus modes
    access(1'b0, 2'd1, 16'h9000, 1'b0, 8'h00, 4'd2, 4'd2, 4'd4, 4'd3, 1'b1);
    access(1'b1, 2'd2, 16'h4321, 1'b1, 8'h5C, 4'd1, 4'd1, 4'd2, 4'd1, 1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule